// File: doc/BRIEF.md
# Systolic all-one-polynomial field multiplier

This block multiplies two elements of GF(2^M), where the field is generated by the all-one polynomial x^M + x^(M-1) + ... + x + 1, which must be irreducible for the chosen M. Inside the block, each operand gets an extra zero coefficient and becomes an (M+1)-bit vector. The product is then a cyclic convolution modulo x^(M+1)+1: the array repeatedly rotates one operand by one position and takes a GF(2) inner product with the other. A last stage folds the top coefficient back into the M-bit field result, using the identity x^M = 1 + x + ... + x^(M-1).

The array has M+1 rows of M+1 identical cells. Each cell has one AND gate and one XOR gate, and registers the bit of A it forwards, the bit of B it forwards and its partial-sum bit. Every row boundary is registered and there is no stall path. The block therefore accepts a new operand pair on every clock and delivers each product a fixed number of cycles later, with a valid flag that travels alongside the data.

Top module: `aop_sys_mult`

## Requirements
- R1: When `out_valid` is high, `c_out` equals the product of the operand pair, reduced modulo the all-one polynomial of degree M. Bit i of a bus is the coefficient of x^i.
- R2: An operand pair sampled with `in_valid` high on a rising edge appears on `c_out`, with `out_valid` high, after exactly M+1 further rising edges. The data passes through M+2 register stages in total.
- R3: Operand pairs presented on consecutive cycles produce products on consecutive cycles, in the same order and with no gaps.
- R4: `out_valid` is the value of `in_valid` delayed by M+2 register stages. A cycle with `in_valid` low yields exactly one cycle with `out_valid` low.
- R5: A synchronous active-high `rst` clears the whole pipeline. After an edge with `rst` high, `out_valid` and `c_out` stay zero until new valid operands have travelled through all M+2 stages. Operands that were in flight before the reset never appear.
- R6: In every cycle where `out_valid` is low, `c_out` reads zero. Operand values presented with `in_valid` low have no effect on the output.
- R7: Multiplying any element by the element 1 (value 1) returns that element. Multiplying by zero returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of every cell and of the valid pipeline |
| in_valid | input | 1 | Marks `a_in`/`b_in` as an operand pair to multiply |
| a_in | input | M | First field operand, polynomial basis |
| b_in | input | M | Second field operand, polynomial basis |
| out_valid | output | 1 | Marks `c_out` as a finished product |
| c_out | output | M | Field product, polynomial basis; zero when not valid |

## Verification
Every product is due M+1 rising edges after the edge that samples its operands, and `out_valid` follows the same delay. The bench keeps a numbered history of what it drove. On each falling edge it compares the outputs with the entry driven M+2 falling edges earlier, so the result of a pair driven at falling edge n is expected at falling edge n+M+2. When a reset is applied, the bench marks the in-flight entries as invalid, so the M+2 cycles that follow must show a zero output. The bench drives all 2^M x 2^M pairs back to back, then random pairs with random bubbles and a mid-stream reset, all compared against a shift-and-reduce reference function.

// File: rtl/aop_sys_mult.sv
module aop_sys_mult #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         out_valid,
  output logic [M-1:0] c_out
);
  localparam int N = M + 1;

  logic [N-1:0] a_ext, b_ext;
  logic [N-1:0] a_q [N-1];
  logic [N-1:0] b_q [N-1];
  logic [N-1:0] s_q [N];
  logic [N-1:0] v_q;

  assign a_ext = in_valid ? {1'b0, a_in} : '0;
  assign b_ext = in_valid ? {1'b0, b_in} : '0;

  genvar r;
  generate
    for (r = 0; r < N; r++) begin : g_row
      logic [N-1:0] a_src, b_src, s_src;
      if (r == 0) begin : g_first
        assign a_src = a_ext;
        assign b_src = b_ext;
        assign s_src = '0;
      end else begin : g_next
        assign a_src = a_q[r-1];
        assign b_src = b_q[r-1];
        assign s_src = s_q[r-1];
      end

      always_ff @(posedge clk) begin
        if (rst) s_q[r] <= '0;
        else     s_q[r] <= s_src ^ ({N{a_src[0]}} & b_src);
      end

      if (r < N - 1) begin : g_fwd
        always_ff @(posedge clk) begin
          if (rst) begin
            a_q[r] <= '0;
            b_q[r] <= '0;
          end else begin
            a_q[r] <= a_src >> 1;
            b_q[r] <= {b_src[N-2:0], b_src[N-1]};
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= '0;
      out_valid <= 1'b0;
      c_out     <= '0;
    end else begin
      v_q       <= {v_q[N-2:0], in_valid};
      out_valid <= v_q[N-1];
      c_out     <= s_q[N-1][M-1:0] ^ {M{s_q[N-1][M]}};
    end
  end
endmodule

// File: rtl/aop_sys_mult_chk.sv
module aop_sys_mult_chk #(
  parameter int M = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [M-1:0] a_in,
  input logic [M-1:0] b_in,
  input logic         out_valid,
  input logic [M-1:0] c_out
);
  localparam int LAT = M + 2;

  logic [LAT-1:0] vsh, zsh;
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      vsh <= '0;
      zsh <= '0;
    end else begin
      vsh <= {vsh[LAT-2:0], in_valid};
      zsh <= {zsh[LAT-2:0], in_valid && (a_in == '0 || b_in == '0)};
    end
  end

  a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[LAT-1]);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> c_out == '0);

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
    zsh[LAT-1] |-> (out_valid && c_out == '0));

  always @(posedge clk) begin
    if (rst_q) begin
      a_r5_reset_clear: assert (!out_valid && c_out == '0);
    end
  end
endmodule

bind aop_sys_mult aop_sys_mult_chk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
  .out_valid(out_valid), .c_out(c_out)
);

// File: tb/aop_sys_mult_tb.sv
module aop_sys_mult_tb;
  localparam int M   = 4;
  localparam int LAT = M + 2;
  localparam int SZ  = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [M-1:0] a_in = '0, b_in = '0;
  logic out_valid;
  logic [M-1:0] c_out;

  int errors = 0, checks = 0, cnt = 0, last_rst = -100;
  bit done = 1'b0;
  bit hv [SZ];
  logic [M-1:0] ha [SZ];
  logic [M-1:0] hb [SZ];
  string ht [SZ];

  always #2 clk = ~clk;

  aop_sys_mult #(.M(M)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .c_out(c_out)
  );

  function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-2:0] p;
    logic [2*M-2:0] poly;
    p = '0;
    poly = '0;
    for (int i = 0; i <= M; i++) poly[i] = 1'b1;
    for (int i = 0; i < M; i++) if (b[i]) p = p ^ ({{(M-1){1'b0}}, a} << i);
    for (int k = 2*M-2; k >= M; k--) if (p[k]) p = p ^ (poly << (k - M));
    return p[M-1:0];
  endfunction

  task automatic check_out(input int n);
    bit ev;
    logic [M-1:0] ec;
    string tag;
    int idx;
    idx = (n - LAT) % SZ;
    ev = (n >= LAT) ? hv[idx] : 1'b0;
    ec = ev ? gf_mul(ha[idx], hb[idx]) : '0;
    tag = (n - last_rst <= LAT + 1) ? "R5" : "R2 R4";
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL %s cycle %0d: out_valid=%b expected %b", tag, n, out_valid, ev);
    end
    checks++;
    if (c_out !== ec) begin
      errors++;
      if (ev) $display("FAIL %s cycle %0d: c_out=%h expected %h (a=%h b=%h)",
                       ht[idx], n, c_out, ec, ha[idx], hb[idx]);
      else    $display("FAIL R6 %s cycle %0d: c_out=%h expected %h", tag, n, c_out, ec);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [M-1:0] a,
                      input logic [M-1:0] b, input string tag);
    int n;
    @(negedge clk);
    n = cnt;
    if (n >= 1) check_out(n);
    rst = r;
    in_valid = v;
    a_in = a;
    b_in = b;
    hv[n % SZ] = v && !r;
    ha[n % SZ] = a;
    hb[n % SZ] = b;
    ht[n % SZ] = tag;
    if (r) begin
      last_rst = n;
      for (int k = 0; k < LAT; k++) if (n - k >= 0) hv[(n - k) % SZ] = 1'b0;
    end
    cnt++;
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, '1, '1, "R5");
    // R3 R1: exhaustive back-to-back stream
    for (int a = 0; a < (1 << M); a++)
      for (int b = 0; b < (1 << M); b++)
        step(1'b0, 1'b1, a[M-1:0], b[M-1:0], "R1 R3");
    // R7: identity and zero directed
    for (int a = 0; a < (1 << M); a++) begin
      step(1'b0, 1'b1, a[M-1:0], 1, "R7");
      step(1'b0, 1'b1, 0, a[M-1:0], "R7");
    end
    // R6: garbage with in_valid low, then random with bubbles
    for (int i = 0; i < 300; i++) begin
      logic [M-1:0] ra, rb;
      bit rv;
      ra = M'($urandom);
      rb = M'($urandom);
      rv = ($urandom % 10) < 7;
      step(1'b0, rv, ra, rb, rv ? "R1" : "R6");
    end
    // R5: reset in the middle of a full pipeline
    for (int i = 0; i < LAT; i++) step(1'b0, 1'b1, '1, M'(i + 3), "R1");
    step(1'b1, 1'b1, '1, '1, "R5");
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, '1, '1, "R5");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, M'($urandom), M'($urandom), "R1");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, '0, "R6");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule